// File: doc/BRIEF.md
# Row-Column Addressed Byte Memory

This block is a small random-access store of 256 bytes, assembled from single-bit storage cells. In each bit-plane the cells sit in a square grid of 16 rows and 16 columns. The address is split into a row number and a column number. Each number is decoded onto its own set of one-hot select lines. A cell is written only at the crossing of the active row line and the active column line, and only while the global write enable is high. Every other cell keeps its contents, whatever is on the data line.

Eight identical bit-planes receive the same address and the same enables. Plane k holds bit k of each byte, so the stack behaves as one byte-wide bank. A read uses the same row and column selects to gate the addressed cell onto the plane's output. The eight plane outputs are captured into a registered byte output with a valid flag. A surrounding datapath drives an address with a write or a read strobe. It sees read data one cycle after the strobe.

Top module: `bitgrid_memory`

## Requirements
- R1: While `rst_n` is low, every stored bit is cleared to 0, and `rd_data` and `rd_valid` are 0. After reset, a read of any address returns 8'h00.
- R2: Address bits [7:4] select the row and bits [3:0] select the column. For example, row 12 and column 8 form address 8'hC8. Swapping the two fields (8'h8C) addresses a different location.
- R3: Each 4-bit field is decoded onto exactly one of 16 select lines. Code n activates line n.
- R4: When `wr_en` is high at a rising clock edge, the byte on `wr_data` is stored at `addr`, with `wr_data[k]` going into plane k. A later read of that address returns the same byte.
- R5: A write to one address leaves the contents of all other 255 addresses unchanged.
- R6: While `wr_en` is low, no stored bit changes, whatever `addr` and `wr_data` do.
- R7: When `rd_en` is high at a rising edge, then from that edge `rd_data` holds the byte stored at `addr` and `rd_valid` is 1, until the next edge.
- R8: When `rd_en` is low at a rising edge, then from that edge `rd_data` is 8'h00 and `rd_valid` is 0.
- R9: When `rd_en` and `wr_en` are both high at the same edge, the read returns the byte held before that edge. The write still takes effect and is seen by later reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with the clock |
| addr | input | 8 | Row number in [7:4], column number in [3:0] |
| wr_en | input | 1 | Global write enable |
| rd_en | input | 1 | Read enable |
| wr_data | input | 8 | Byte to store; bit k goes to plane k |
| rd_data | output | 8 | Registered read byte; 0 when no read was made |
| rd_valid | output | 1 | High for the cycle after a read strobe |

## Verification
The bound checker checks on every cycle that both decoders are one-hot and follow their address fields, and that an idle cycle leaves the output at zero with valid low. It also checks that a read strobe raises valid, that reset clears the output, and that repeated reads of one address with no write in between return a stable byte. Three behaviours are shown only by the bench's scenarios: isolation between addresses, hold under a toggling data line, and the old-value result of a combined read and write. Each of these needs a model of all 256 locations.

// File: rtl/bitgrid_pkg.sv
package bitgrid_pkg;

  // Kind of access requested in a cycle.
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_READ  = 2'b10,
    ACC_RDWR  = 2'b11
  } access_e;

  function automatic access_e classify(input logic rd, input logic wr);
    return access_e'({rd, wr});
  endfunction

  function automatic logic has_read(input access_e a);
    return (a == ACC_READ) || (a == ACC_RDWR);
  endfunction

endpackage

// File: rtl/grid_line_decoder.sv
module grid_line_decoder #(
  parameter int SEL_BITS = 4,
  localparam int LINES = 1 << SEL_BITS
) (
  input  logic [SEL_BITS-1:0] code,
  output logic [LINES-1:0]    lines
);

  // One comparator per select line.
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lines[i] = (code == SEL_BITS'(i));
  end

endmodule

// File: rtl/grid_cell.sv
module grid_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_gate,
  input  logic d,
  output logic q
);

  logic q_next;

  // Next state: take the data bit only while the gate is open.
  always_comb begin
    q_next = q;
    if (wr_gate) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_next;
  end

endmodule

// File: rtl/grid_bit_plane.sv
module grid_bit_plane #(
  parameter int ROWS = 16,
  parameter int COLS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ROWS-1:0] row_sel,
  input  logic [COLS-1:0] col_sel,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic            d_bit,
  output logic            q_bit
);

  logic [ROWS-1:0][COLS-1:0] cell_q;
  logic [ROWS-1:0]           row_hit;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic gate;
      // A cell is write-enabled only where both select lines cross the enable.
      assign gate = row_sel[r] & col_sel[c] & wr_en;
      grid_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_gate (gate),
        .d       (d_bit),
        .q       (cell_q[r][c])
      );
    end
    // The column selects pick one cell in the row, then the row select gates it.
    assign row_hit[r] = row_sel[r] & (|(cell_q[r] & col_sel));
  end

  assign q_bit = rd_en & (|row_hit);

endmodule

// File: rtl/bitgrid_memory.sv
module bitgrid_memory
  import bitgrid_pkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = ROW_BITS + COL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int ROWS = 1 << ROW_BITS;
  localparam int COLS = 1 << COL_BITS;

  logic [ROW_BITS-1:0] row_field;
  logic [COL_BITS-1:0] col_field;
  logic [ROWS-1:0]     row_sel;
  logic [COLS-1:0]     col_sel;
  logic [DATA_W-1:0]   plane_bits;
  logic [DATA_W-1:0]   rd_data_next;
  logic                rd_valid_next;
  access_e             access;

  // Row number in the upper field, column number in the lower one.
  assign row_field = addr[ADDR_W-1 -: ROW_BITS];
  assign col_field = addr[COL_BITS-1:0];

  grid_line_decoder #(.SEL_BITS(ROW_BITS)) u_row_dec (
    .code  (row_field),
    .lines (row_sel)
  );

  grid_line_decoder #(.SEL_BITS(COL_BITS)) u_col_dec (
    .code  (col_field),
    .lines (col_sel)
  );

  // One plane per data bit, all on the same selects and enables.
  for (genvar k = 0; k < DATA_W; k++) begin : g_plane
    grid_bit_plane #(.ROWS(ROWS), .COLS(COLS)) u_plane (
      .clk     (clk),
      .rst_n   (rst_n),
      .row_sel (row_sel),
      .col_sel (col_sel),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .d_bit   (wr_data[k]),
      .q_bit   (plane_bits[k])
    );
  end

  assign access = classify(rd_en, wr_en);

  // Output next state: the cells still hold pre-edge values, so a read that
  // shares its edge with a write captures the old byte.
  always_comb begin
    rd_valid_next = has_read(access);
    rd_data_next  = '0;
    if (rd_valid_next) rd_data_next = plane_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= rd_data_next;
      rd_valid <= rd_valid_next;
    end
  end

endmodule

// File: rtl/bitgrid_checker.sv
module bitgrid_checker #(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = ROW_BITS + COL_BITS,
  localparam int ROWS    = 1 << ROW_BITS,
  localparam int COLS    = 1 << COL_BITS
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic [ROWS-1:0]   row_sel,
  input logic [COLS-1:0]   col_sel
);

  assert_row_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_sel) == 1);

  assert_col_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(col_sel) == 1);

  assert_row_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
    row_sel[addr[ADDR_W-1 -: ROW_BITS]] == 1'b1);

  assert_col_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
    col_sel[addr[COL_BITS-1:0]] == 1'b1);

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == '0) && !rd_valid);

  assert_read_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // Two reads of one address with no write at the first edge return the same byte.
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en && !wr_en) && rd_en && $stable(addr)) |=> (rd_data == $past(rd_data)));

  // While reset is held, the output is cleared.
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (rd_data == '0 && !rd_valid);
    end
  end

endmodule

bind bitgrid_memory bitgrid_checker #(
  .ROW_BITS (ROW_BITS),
  .COL_BITS (COL_BITS),
  .DATA_W   (DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .row_sel  (row_sel),
  .col_sel  (col_sel)
);

// File: tb/sim_bitgrid_memory.sv
module sim_bitgrid_memory;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;

  logic       clk;
  logic       rst_n;
  logic [7:0] addr;
  logic       wr_en;
  logic       rd_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       rd_valid;

  int checks;
  int errors;
  logic [7:0] model [DEPTH];

  bitgrid_memory u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = d;
  endtask

  // Read strobe at one edge, sample at the following falling edge.
  task automatic do_read(input logic [7:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    addr = a; rd_en = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    d = rd_data; v = rd_valid;
    rd_en = 1'b0;
  endtask

  task automatic test_reset();
    logic [7:0] d; logic v;
    check("R1 out", {rd_valid, rd_data}, 9'h000);
    for (int i = 0; i < DEPTH; i += 51) begin
      do_read(8'(i), d, v);
      check("R1 cleared", {v, d}, {1'b1, 8'h00});
    end
  endtask

  task automatic test_fill_all();
    logic [7:0] d; logic v;
    for (int i = 0; i < DEPTH; i++) do_write(8'(i), 8'(i * 37 + 11));
    for (int i = 0; i < DEPTH; i++) begin
      do_read(8'(i), d, v);
      check("R4 R3 readback", {v, d}, {1'b1, model[i]});
      check("R7 valid", {8'h00, v}, 9'h001);
    end
  endtask

  task automatic test_split();
    logic [7:0] d; logic v;
    do_write(8'hC8, 8'hA5);
    do_write(8'h8C, 8'h5A);
    do_read(8'hC8, d, v);
    check("R2 row12 col8", {v, d}, {1'b1, 8'hA5});
    do_read(8'h8C, d, v);
    check("R2 row8 col12", {v, d}, {1'b1, 8'h5A});
    // Single-bit bytes exercise each plane on its own.
    for (int k = 0; k < 8; k++) begin
      do_write(8'h30 + 8'(k), 8'(1 << k));
      do_read(8'h30 + 8'(k), d, v);
      check("R4 plane bit", {v, d}, {1'b1, 8'(1 << k)});
    end
  endtask

  task automatic test_isolation();
    logic [7:0] d; logic v;
    do_write(8'h77, 8'hFF);
    do_write(8'h00, 8'h00);
    for (int i = 0; i < DEPTH; i++) begin
      do_read(8'(i), d, v);
      check("R5 isolation", {v, d}, {1'b1, model[i]});
    end
  endtask

  task automatic test_hold();
    logic [7:0] d; logic v;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      addr = 8'(i * 13); wr_data = 8'(~(i * 7));
    end
    for (int i = 0; i < 20; i++) begin
      do_read(8'(i * 13), d, v);
      check("R6 hold", {v, d}, {1'b1, model[8'(i * 13)]});
    end
  endtask

  task automatic test_idle();
    do_write(8'h42, 8'h99);
    @(negedge clk);
    addr = 8'h42; rd_en = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    check("R8 idle", {rd_valid, rd_data}, 9'h000);
  endtask

  task automatic test_read_write();
    logic [7:0] d; logic v;
    logic [7:0] old;
    old = model[8'hE1];
    @(negedge clk);
    addr = 8'hE1; wr_data = 8'h3C; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    check("R9 old value", {rd_valid, rd_data}, {1'b1, old});
    wr_en = 1'b0; rd_en = 1'b0;
    model[8'hE1] = 8'h3C;
    do_read(8'hE1, d, v);
    check("R9 new value", {v, d}, {1'b1, 8'h3C});
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    test_reset_pre: begin
      check("R1 in reset", {rd_valid, rd_data}, 9'h000);
    end
    rst_n = 1'b1;
    test_reset();
    test_fill_all();
    test_split();
    test_isolation();
    test_hold();
    test_idle();
    test_read_write();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule